// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Next-PC Unit

This block owns the program counter and the fetch-to-decode pipeline register of a five-stage in-order integer pipeline. Each cycle it presents a fetch address, captures the returned instruction word together with its address, and looks at the instruction in decode. When that instruction is a conditional branch or an unconditional jump, the block resolves it in decode. It computes the taken target with its own adder. The only condition it evaluates is whether a single forwarded register operand is zero. It then steers the next fetch address and, when needed, turns the word being fetched into a bubble.

A build-time parameter picks one of three control-hazard policies. In the first, fetch is held while a control instruction is in decode, which costs exactly one bubble whether or not the branch is taken. In the second, fetch keeps going sequentially and the wrong-path word is squashed only when the branch is taken. In the third, the instruction that follows a branch is always executed and the redirect lands after it, so no bubbles are inserted. A stall input from the hazard logic freezes the PC and the fetch-to-decode register and defers any pending redirect.

Top module: `brc_nextpc_unit`

## Requirements
- R1: While reset is asserted and right after it, the fetch PC is zero and the fetch-to-decode register is invalid.
- R2: With no control instruction in decode and no stall, the fetch PC advances by 4 every cycle. The fetch-to-decode register then captures the fetched word and its PC with the valid bit set.
- R3: The opcode sits in bits 31..26. Opcode 6'h04 is taken when the forwarded operand (the register named by bits 25..21) equals zero. Opcode 6'h05 is taken when that operand is non-zero. Opcode 6'h02 is an unconditional jump. All other opcodes are not control instructions.
- R4: A taken branch redirects fetch to (decode PC + 4) + (sign-extended bits 15..0 shifted left by two).
- R5: A jump redirects fetch to bits 31..28 of (decode PC + 4), followed by bits 25..0 of the word, followed by two zero bits.
- R6: Stall policy (0): while a valid control instruction is in decode, the word being fetched is discarded as a bubble. The PC then either repeats (not taken) or moves to the target (taken), so every control instruction costs exactly one bubble.
- R7: Predict-not-taken policy (1): a not-taken branch costs no bubble. A taken branch or jump squashes the word fetched behind it into one bubble, and fetch moves to the target.
- R8: Delay-slot policy (2): the instruction that follows a control instruction always enters decode valid. The redirect takes effect on the fetch right after it, so no bubble is inserted.
- R9: While the stall input is high, the PC and the fetch-to-decode register keep their values and neither redirect nor squash is signalled. A control instruction held in decode resolves once the stall drops.
- R10: An invalid (bubble) decode slot never redirects or squashes, even when its stored word decodes as a control instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Stall from hazard logic: freeze PC and fetch-to-decode register |
| fetch_word_i | input | 32 | Instruction word read at fetch_pc_o this cycle |
| dec_opnd_i | input | OPND_W (32) | Forwarded value of the register named in bits 25..21 of the decode word |
| fetch_pc_o | output | PC_W (32) | Current fetch address |
| dec_valid_o | output | 1 | Fetch-to-decode register holds a real instruction |
| dec_pc_o | output | PC_W (32) | Address of the instruction in decode |
| dec_word_o | output | 32 | Instruction word in decode |
| redirect_o | output | 1 | The next fetch address is a resolved branch or jump target |
| squash_o | output | 1 | The word fetched this cycle enters decode as a bubble |

## Verification
The assertions assume that the word on fetch_word_i belongs to the current fetch PC. They also assume that dec_opnd_i already carries the forwarded value for the decode instruction, and that a control instruction never sits in a delay slot. The stimulus respects all three. The bench's instruction model returns the word for each instance's own fetch PC in the same cycle, and it holds the operand constant for the whole of a scenario. No program places a branch or jump right behind another one, except in the squash scenario, where the second word is meant to become a bubble. The stall input is raised only between clock edges, never while reset is active.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int ILEN   = 32;
    localparam int OPC_HI = 31;
    localparam int OPC_LO = 26;
    localparam int OPC_W  = OPC_HI - OPC_LO + 1;
    localparam int FLD_W  = 26;
    localparam int IMM_W  = 16;

    localparam logic [OPC_W-1:0] OPC_JMP  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_BEQZ = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BNEZ = 6'h05;

    typedef enum logic [1:0] {
        POL_STALL = 2'd0,
        POL_PNT   = 2'd1,
        POL_DELAY = 2'd2
    } policy_e;

    typedef enum logic [1:0] {
        NPC_SEQ  = 2'd0,
        NPC_TGT  = 2'd1,
        NPC_HOLD = 2'd2
    } npc_sel_e;

    typedef enum logic [1:0] {
        CTL_NONE = 2'd0,
        CTL_BEQZ = 2'd1,
        CTL_BNEZ = 2'd2,
        CTL_JMP  = 2'd3
    } ctl_kind_e;

endpackage

// File: rtl/brc_ctl_decode.sv
module brc_ctl_decode
    import brc_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic              valid_i,
    input  logic [OPND_W-1:0] opnd_i,
    output ctl_kind_e         kind_o,
    output logic              is_ctl_o,
    output logic              taken_o
);

    logic opnd_zero;

    always_comb begin
        opnd_zero = (opnd_i == '0);
        case (opcode_i)
            OPC_BEQZ: kind_o = CTL_BEQZ;
            OPC_BNEZ: kind_o = CTL_BNEZ;
            OPC_JMP:  kind_o = CTL_JMP;
            default:  kind_o = CTL_NONE;
        endcase
        is_ctl_o = valid_i && (kind_o != CTL_NONE);
        case (kind_o)
            CTL_BEQZ: taken_o = is_ctl_o && opnd_zero;
            CTL_BNEZ: taken_o = is_ctl_o && !opnd_zero;
            CTL_JMP:  taken_o = is_ctl_o;
            default:  taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen
    import brc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0]  dec_pc_i,
    input  logic [FLD_W-1:0] field_i,
    input  ctl_kind_e        kind_i,
    output logic [PC_W-1:0]  target_o
);

    localparam int SEXT_W = PC_W - IMM_W - 2;
    localparam int JLO    = FLD_W + 2;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] br_tgt;
    logic [PC_W-1:0] jmp_tgt;

    always_comb begin
        seq_pc   = dec_pc_i + PC_W'(4);
        br_tgt   = seq_pc + {{SEXT_W{field_i[IMM_W-1]}}, field_i[IMM_W-1:0], 2'b00};
        jmp_tgt  = {seq_pc[PC_W-1:JLO], field_i, 2'b00};
        target_o = (kind_i == CTL_JMP) ? jmp_tgt : br_tgt;
    end

endmodule

// File: rtl/brc_policy_ctl.sv
module brc_policy_ctl
    import brc_pkg::*;
#(
    parameter policy_e POLICY = POL_PNT
) (
    input  logic     is_ctl_i,
    input  logic     taken_i,
    output npc_sel_e sel_o,
    output logic     kill_o
);

    generate
        if (POLICY == POL_STALL) begin : g_stall
            always_comb begin
                kill_o = is_ctl_i;
                if (!is_ctl_i)    sel_o = NPC_SEQ;
                else if (taken_i) sel_o = NPC_TGT;
                else              sel_o = NPC_HOLD;
            end
        end else if (POLICY == POL_PNT) begin : g_pnt
            always_comb begin
                kill_o = taken_i;
                sel_o  = taken_i ? NPC_TGT : NPC_SEQ;
            end
        end else begin : g_delay
            always_comb begin
                kill_o = 1'b0;
                sel_o  = taken_i ? NPC_TGT : NPC_SEQ;
            end
        end
    endgenerate

endmodule

// File: rtl/brc_nextpc_unit.sv
module brc_nextpc_unit
    import brc_pkg::*;
#(
    parameter int      PC_W   = 32,
    parameter int      OPND_W = 32,
    parameter policy_e POLICY = POL_PNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic [ILEN-1:0]   fetch_word_i,
    input  logic [OPND_W-1:0] dec_opnd_i,
    output logic [PC_W-1:0]   fetch_pc_o,
    output logic              dec_valid_o,
    output logic [PC_W-1:0]   dec_pc_o,
    output logic [ILEN-1:0]   dec_word_o,
    output logic              redirect_o,
    output logic              squash_o
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            fd_valid;
        logic [PC_W-1:0] fd_pc;
        logic [ILEN-1:0] fd_word;
    } state_t;

    state_t    st_q, st_d;
    ctl_kind_e kind;
    logic      is_ctl;
    logic      taken;
    logic      kill;
    npc_sel_e  sel;
    logic [PC_W-1:0] target;

    brc_ctl_decode #(.OPND_W(OPND_W)) u_dec (
        .opcode_i (st_q.fd_word[OPC_HI:OPC_LO]),
        .valid_i  (st_q.fd_valid),
        .opnd_i   (dec_opnd_i),
        .kind_o   (kind),
        .is_ctl_o (is_ctl),
        .taken_o  (taken)
    );

    brc_target_gen #(.PC_W(PC_W)) u_tgt (
        .dec_pc_i (st_q.fd_pc),
        .field_i  (st_q.fd_word[FLD_W-1:0]),
        .kind_i   (kind),
        .target_o (target)
    );

    brc_policy_ctl #(.POLICY(POLICY)) u_pol (
        .is_ctl_i (is_ctl),
        .taken_i  (taken),
        .sel_o    (sel),
        .kill_o   (kill)
    );

    always_comb begin
        st_d       = st_q;
        redirect_o = 1'b0;
        squash_o   = 1'b0;
        if (!hold_i) begin
            redirect_o = (sel == NPC_TGT);
            squash_o   = kill;
            case (sel)
                NPC_TGT:  st_d.pc = target;
                NPC_HOLD: st_d.pc = st_q.pc;
                default:  st_d.pc = st_q.pc + PC_W'(4);
            endcase
            st_d.fd_valid = !kill;
            st_d.fd_pc    = st_q.pc;
            st_d.fd_word  = fetch_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc_o  = st_q.pc;
    assign dec_valid_o = st_q.fd_valid;
    assign dec_pc_o    = st_q.fd_pc;
    assign dec_word_o  = st_q.fd_word;

endmodule

// File: rtl/brc_nextpc_chk.sv
module brc_nextpc_chk
    import brc_pkg::*;
#(
    parameter int      PC_W   = 32,
    parameter policy_e POLICY = POL_PNT
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hold_i,
    input logic [PC_W-1:0] fetch_pc_o,
    input logic            dec_valid_o,
    input logic [PC_W-1:0] dec_pc_o,
    input logic [ILEN-1:0] dec_word_o,
    input logic            redirect_o,
    input logic            squash_o
);

    localparam logic IS_STALL = (POLICY == POL_STALL);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (fetch_pc_o == '0 && !dec_valid_o));

    p_fill_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !squash_o) |=> (dec_valid_o && dec_pc_o == $past(fetch_pc_o)));

    p_seq_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !redirect_o && !(IS_STALL && squash_o))
            |=> fetch_pc_o == $past(fetch_pc_o) + PC_W'(4));

    p_stall_refetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_STALL && squash_o && !redirect_o) |=> $stable(fetch_pc_o));

    p_squash_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> !dec_valid_o);

    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> (!redirect_o && !squash_o));

    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> ($stable(fetch_pc_o) && $stable(dec_valid_o)
                    && $stable(dec_pc_o) && $stable(dec_word_o)));

    p_bubble_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_o |-> (!redirect_o && !squash_o));

endmodule

bind brc_nextpc_unit brc_nextpc_chk #(.PC_W(PC_W), .POLICY(POLICY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (hold_i),
    .fetch_pc_o  (fetch_pc_o),
    .dec_valid_o (dec_valid_o),
    .dec_pc_o    (dec_pc_o),
    .dec_word_o  (dec_word_o),
    .redirect_o  (redirect_o),
    .squash_o    (squash_o)
);

// File: tb/tb_brc_nextpc_unit.sv
`timescale 1ns/1ps
module tb_brc_nextpc_unit;
    import brc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold = 1'b0;
    logic [31:0] opnd = '0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    logic [31:0] slot_pc [4];
    logic [31:0] slot_w  [4];

    function automatic logic [31:0] imem(input logic [31:0] a);
        logic [31:0] w;
        w = {6'h3F, a[27:2]};
        for (int i = 0; i < 4; i++) if (slot_pc[i] == a) w = slot_w[i];
        return w;
    endfunction

    function automatic logic [31:0] enc_br(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd3, 5'd0, imm};
    endfunction

    logic [31:0] pc_p, pc_s, pc_d, dpc_p, dpc_s, dpc_d, dw_p, dw_s, dw_d;
    logic v_p, v_s, v_d, rd_p, rd_s, rd_d, sq_p, sq_s, sq_d;
    logic [31:0] w_p, w_s, w_d;

    assign w_p = imem(pc_p);
    assign w_s = imem(pc_s);
    assign w_d = imem(pc_d);

    brc_nextpc_unit #(.POLICY(POL_PNT)) dut (
        .clk(clk), .rst_n(rst_n), .hold_i(hold), .fetch_word_i(w_p), .dec_opnd_i(opnd),
        .fetch_pc_o(pc_p), .dec_valid_o(v_p), .dec_pc_o(dpc_p), .dec_word_o(dw_p),
        .redirect_o(rd_p), .squash_o(sq_p));

    brc_nextpc_unit #(.POLICY(POL_STALL)) dut_stl (
        .clk(clk), .rst_n(rst_n), .hold_i(hold), .fetch_word_i(w_s), .dec_opnd_i(opnd),
        .fetch_pc_o(pc_s), .dec_valid_o(v_s), .dec_pc_o(dpc_s), .dec_word_o(dw_s),
        .redirect_o(rd_s), .squash_o(sq_s));

    brc_nextpc_unit #(.POLICY(POL_DELAY)) dut_dly (
        .clk(clk), .rst_n(rst_n), .hold_i(hold), .fetch_word_i(w_d), .dec_opnd_i(opnd),
        .fetch_pc_o(pc_d), .dec_valid_o(v_d), .dec_pc_o(dpc_d), .dec_word_o(dw_d),
        .redirect_o(rd_d), .squash_o(sq_d));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // which: 0 predict-not-taken, 1 stall, 2 delay slot
    task automatic see(input string tag, input int which, input logic ev,
                       input logic [31:0] edpc, input logic [31:0] efpc);
        case (which)
            0: begin chk({tag, " valid"}, 32'(v_p), 32'(ev));
                     if (ev) chk({tag, " dec_pc"}, dpc_p, edpc);
                     chk({tag, " fetch_pc"}, pc_p, efpc); end
            1: begin chk({tag, " valid"}, 32'(v_s), 32'(ev));
                     if (ev) chk({tag, " dec_pc"}, dpc_s, edpc);
                     chk({tag, " fetch_pc"}, pc_s, efpc); end
            default: begin chk({tag, " valid"}, 32'(v_d), 32'(ev));
                     if (ev) chk({tag, " dec_pc"}, dpc_d, edpc);
                     chk({tag, " fetch_pc"}, pc_d, efpc); end
        endcase
    endtask

    task automatic clear_slots();
        for (int i = 0; i < 4; i++) begin
            slot_pc[i] = 32'hFFFF_FFFF;
            slot_w[i]  = '0;
        end
    endtask

    task automatic do_reset();
        hold = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #0.1;
    endtask

    task automatic t_reset();
        clear_slots();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        see("R1 pnt in reset", 0, 1'b0, 0, 32'h0);
        see("R1 stall in reset", 1, 1'b0, 0, 32'h0);
        see("R1 delay in reset", 2, 1'b0, 0, 32'h0);
        rst_n = 1'b1;
        #0.1;
        see("R1 after release", 0, 1'b0, 0, 32'h0);
    endtask

    task automatic t_sequential();
        clear_slots();
        do_reset();
        step(3);
        see("R2 pnt", 0, 1'b1, 32'd8, 32'd12);
        see("R2 stall", 1, 1'b1, 32'd8, 32'd12);
        see("R2 delay", 2, 1'b1, 32'd8, 32'd12);
        chk("R2 dec_word", dw_p, imem(32'd8));
    endtask

    task automatic t_beqz_taken();
        clear_slots();
        slot_pc[0] = 32'd8; slot_w[0] = enc_br(OPC_BEQZ, 16'd5);
        opnd = '0;
        do_reset();
        step(3);
        chk("R3 pnt redirect", 32'(rd_p), 1);
        chk("R7 pnt squash", 32'(sq_p), 1);
        chk("R6 stall squash", 32'(sq_s), 1);
        chk("R8 delay squash", 32'(sq_d), 0);
        step(1);
        see("R4 R7 pnt", 0, 1'b0, 0, 32'd32);
        see("R4 R6 stall", 1, 1'b0, 0, 32'd32);
        see("R8 delay slot", 2, 1'b1, 32'd12, 32'd32);
        step(1);
        see("R7 pnt target", 0, 1'b1, 32'd32, 32'd36);
        see("R6 stall target", 1, 1'b1, 32'd32, 32'd36);
        see("R8 delay target", 2, 1'b1, 32'd32, 32'd36);
    endtask

    task automatic t_beqz_not_taken();
        clear_slots();
        slot_pc[0] = 32'd8; slot_w[0] = enc_br(OPC_BEQZ, 16'd5);
        opnd = 32'd7;
        do_reset();
        step(3);
        chk("R3 no redirect", 32'(rd_p), 0);
        chk("R7 pnt no squash", 32'(sq_p), 0);
        chk("R6 stall squash", 32'(sq_s), 1);
        step(1);
        see("R7 pnt fallthrough", 0, 1'b1, 32'd12, 32'd16);
        see("R6 stall refetch", 1, 1'b0, 0, 32'd12);
        see("R8 delay fallthrough", 2, 1'b1, 32'd12, 32'd16);
        step(1);
        see("R6 stall resumes", 1, 1'b1, 32'd12, 32'd16);
    endtask

    task automatic t_bnez();
        clear_slots();
        slot_pc[0] = 32'd8; slot_w[0] = enc_br(OPC_BNEZ, 16'hFFFD);
        opnd = 32'd1;
        do_reset();
        step(4);
        see("R4 backward pnt", 0, 1'b0, 0, 32'd0);
        see("R4 backward stall", 1, 1'b0, 0, 32'd0);
        step(1);
        see("R4 backward pnt land", 0, 1'b1, 32'd0, 32'd4);
        opnd = '0;
        do_reset();
        step(4);
        see("R3 bnez zero not taken", 0, 1'b1, 32'd12, 32'd16);
    endtask

    task automatic t_jump();
        clear_slots();
        slot_pc[0] = 32'd8;          slot_w[0] = {OPC_JMP, 26'h3FF_FFFF};
        slot_pc[1] = 32'h0FFF_FFFC;  slot_w[1] = {OPC_JMP, 26'h10};
        opnd = 32'd9;
        do_reset();
        step(4);
        see("R5 pnt jump", 0, 1'b0, 0, 32'h0FFF_FFFC);
        see("R5 delay jump", 2, 1'b1, 32'd12, 32'h0FFF_FFFC);
        step(1);
        chk("R5 pnt second redirect", 32'(rd_p), 1);
        see("R5 pnt at jump", 0, 1'b1, 32'h0FFF_FFFC, 32'h1000_0000);
        step(1);
        see("R5 pnt upper bits", 0, 1'b0, 0, 32'h1000_0040);
        see("R8 delay slot across jump", 2, 1'b1, 32'h1000_0000, 32'h1000_0040);
    endtask

    task automatic t_hold();
        clear_slots();
        slot_pc[0] = 32'd8; slot_w[0] = enc_br(OPC_BEQZ, 16'd5);
        opnd = '0;
        do_reset();
        step(3);
        hold = 1'b1;
        #0.1;
        chk("R9 no redirect", 32'(rd_p), 0);
        chk("R9 no squash", 32'(sq_p), 0);
        step(2);
        see("R9 pnt frozen", 0, 1'b1, 32'd8, 32'd12);
        see("R9 stall frozen", 1, 1'b1, 32'd8, 32'd12);
        hold = 1'b0;
        #0.1;
        chk("R9 redirect after release", 32'(rd_p), 1);
        step(1);
        see("R9 resolved", 0, 1'b0, 0, 32'd32);
    endtask

    task automatic t_bubble();
        clear_slots();
        slot_pc[0] = 32'd8;  slot_w[0] = enc_br(OPC_BEQZ, 16'd5);
        slot_pc[1] = 32'd12; slot_w[1] = {OPC_JMP, 26'h0};
        opnd = '0;
        do_reset();
        step(4);
        chk("R10 bubble holds jump word", dw_p, {OPC_JMP, 26'h0});
        chk("R10 valid", 32'(v_p), 0);
        chk("R10 no redirect", 32'(rd_p), 0);
        chk("R10 no squash", 32'(sq_p), 0);
        step(1);
        see("R10 sequential after bubble", 0, 1'b1, 32'd32, 32'd36);
    endtask

    initial begin
        clear_slots();
        t_reset();
        t_sequential();
        t_beqz_taken();
        t_beqz_not_taken();
        t_bnez();
        t_jump();
        t_hold();
        t_bubble();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule